// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This unit computes, for one single-register memory access, the address to present to memory and the updated value of the base register. It combines a 32-bit base with an offset. The offset is either a zero-extended 12-bit immediate or a register operand that has passed through a barrel shifter. An add/subtract flag chooses whether the offset is added to the base or subtracted from it.

Three addressing modes decide which value goes to memory and whether the base is rewritten. Offset mode sends base ± offset to memory and rewrites nothing. Pre-indexed mode sends base ± offset to memory and also writes it back. Post-indexed mode sends the unmodified base to memory and writes base ± offset back. The access size is carried alongside the address.

Every result is captured in output registers on the clock edge at which the request input is high. A one-cycle valid strobe follows in the next cycle.

Top module: `lsu_agen`

## Requirements
- R1: With `mode_i` = 00 (offset), `addr_o` = base ± offset, `wb_val_o` carries the same sum and `wb_en_o` stays 0.
- R2: With `mode_i` = 01 (pre-indexed), `addr_o` = base ± offset, `wb_en_o` = 1 and `wb_val_o` equals `addr_o`.
- R3: With `mode_i` = 10 (post-indexed), `addr_o` is the unmodified base, `wb_en_o` = 1 and `wb_val_o` = base ± offset.
- R4: `mode_i` = 11 is reserved and behaves exactly like offset mode, with no writeback.
- R5: With `use_reg_i` = 0 the offset is `imm_i` zero-extended to 32 bits, and `roff_i`, `shtype_i` and `shamt_i` have no effect.
- R6: With `use_reg_i` = 1 the offset is `roff_i` shifted by `shamt_i`. `shtype_i` selects 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right.
- R7: A shift amount of 0 passes `roff_i` through unchanged for every shift type.
- R8: `sub_i` = 1 subtracts the offset and `sub_i` = 0 adds it. All arithmetic wraps modulo 2^32.
- R9: `size_o` follows `size_i`, with the encoding 00 byte, 01 halfword, 10 word. The unused code 11 is delivered as 10 (word).
- R10: Results appear one cycle after a clock edge with `req_i` = 1, and `valid_o` is high in that cycle only. After an edge with `req_i` = 0, `valid_o` and `wb_en_o` are 0 and `addr_o`, `wb_val_o` and `size_o` hold their values.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Compute and capture an address this cycle |
| base_i | input | 32 | Base register value |
| use_reg_i | input | 1 | 1: shifted register offset, 0: immediate offset |
| imm_i | input | 12 | Unsigned immediate offset |
| roff_i | input | 32 | Register offset operand |
| shtype_i | input | 2 | Shift type: 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| shamt_i | input | 5 | Shift amount |
| sub_i | input | 1 | 1: subtract offset, 0: add offset |
| mode_i | input | 2 | 00 offset, 01 pre-indexed, 10 post-indexed, 11 reserved (as offset) |
| size_i | input | 2 | 00 byte, 01 halfword, 10 word |
| addr_o | output | 32 | Memory address |
| size_o | output | 2 | Access size |
| wb_en_o | output | 1 | Base writeback enable |
| wb_val_o | output | 32 | New base value |
| valid_o | output | 1 | Results valid strobe |

## Verification
The bench first sends the post-indexed case. A design that confuses it with pre-indexing presents the incremented address to memory instead of the old base. Further vectors carry the offset past 2^32 in both directions, so a design that does not wrap produces a wrong sum. Others use an arithmetic right shift of a negative operand and a rotate with a nonzero amount; a design that fills with zeros, or rotates the wrong way, gives a different address. Shift amount 0 is tried with the arithmetic and rotate types, where a naive rotate doubles bits. A register operand is left nonzero while the immediate is selected, and the reserved mode and size codes are exercised. The bench also checks that an idle cycle drops the strobe and writeback while the address holds.

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int AW   = 32,
  parameter int IMMW = 12,
  localparam int SHW = $clog2(AW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [AW-1:0] base_i,
  input  logic          use_reg_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic [AW-1:0] roff_i,
  input  logic [1:0]    shtype_i,
  input  logic [SHW-1:0] shamt_i,
  input  logic          sub_i,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    size_i,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    size_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_val_o,
  output logic          valid_o
);

  localparam logic [1:0] M_PRE  = 2'b01;
  localparam logic [1:0] M_POST = 2'b10;

  logic [2*AW-1:0] rot_wide;
  logic [AW-1:0]   shifted, offset, sum, next_addr;
  logic [1:0]      next_size;
  logic            indexed;

  assign rot_wide = {roff_i, roff_i} >> shamt_i;

  always_comb begin
    unique case (shtype_i)
      2'b00:   shifted = roff_i << shamt_i;
      2'b01:   shifted = roff_i >> shamt_i;
      2'b10:   shifted = $unsigned($signed(roff_i) >>> shamt_i);
      default: shifted = rot_wide[AW-1:0];
    endcase
  end

  assign offset    = use_reg_i ? shifted : {{(AW-IMMW){1'b0}}, imm_i};
  assign sum       = sub_i ? base_i - offset : base_i + offset;
  assign indexed   = (mode_i == M_PRE) || (mode_i == M_POST);
  assign next_addr = (mode_i == M_POST) ? base_i : sum;
  assign next_size = (size_i == 2'b11) ? 2'b10 : size_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_o   <= '0;
      size_o   <= '0;
      wb_en_o  <= 1'b0;
      wb_val_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= req_i;
      wb_en_o <= req_i & indexed;
      if (req_i) begin
        addr_o   <= next_addr;
        size_o   <= next_size;
        wb_val_o <= sum;
      end
    end
  end

  p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> valid_o);
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (!valid_o && $stable(addr_o) && $stable(wb_val_o)));
  p_wb_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> !wb_en_o);
  p_no_wb_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i == 2'b00) |=> !wb_en_o);
  p_no_wb_resv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i == 2'b11) |=> !wb_en_o);
  p_pre_same_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i == M_PRE) |=> (wb_en_o && addr_o == wb_val_o));
  p_post_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i == M_POST) |=> (wb_en_o && addr_o == $past(base_i)));
  p_size_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> size_o != 2'b11);
  p_reset_r11: assert property (@(posedge clk)
    !rst_n |=> (!valid_o && !wb_en_o && addr_o == '0));

endmodule

// File: tb/lsu_agen_tb.sv
`timescale 1ns/1ps
module lsu_agen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_i = 1'b0;
  logic [31:0] base_i = '0, roff_i = '0;
  logic use_reg_i = 1'b0, sub_i = 1'b0;
  logic [11:0] imm_i = '0;
  logic [1:0] shtype_i = '0, mode_i = '0, size_i = '0;
  logic [4:0] shamt_i = '0;
  logic [31:0] addr_o, wb_val_o;
  logic [1:0] size_o;
  logic wb_en_o, valid_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lsu_agen dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .base_i(base_i),
    .use_reg_i(use_reg_i), .imm_i(imm_i), .roff_i(roff_i),
    .shtype_i(shtype_i), .shamt_i(shamt_i), .sub_i(sub_i),
    .mode_i(mode_i), .size_i(size_i), .addr_o(addr_o), .size_o(size_o),
    .wb_en_o(wb_en_o), .wb_val_o(wb_val_o), .valid_o(valid_o)
  );

  typedef struct packed {
    logic [31:0] base; logic use_reg; logic [11:0] imm; logic [31:0] roff;
    logic [1:0] sht; logic [4:0] sha; logic sub; logic [1:0] mode; logic [1:0] size;
    logic [31:0] e_addr; logic e_wb; logic [31:0] e_wbv; logic [1:0] e_size;
    logic [7:0] rq;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    // R3: post-indexed, memory gets the old base
    '{32'h0000_2000, 1'b0, 12'h0FF, 32'h0, 2'b00, 5'd0, 1'b0, 2'b10, 2'b01, 32'h0000_2000, 1'b1, 32'h0000_20FF, 2'b01, 8'd3},
    // R1: offset mode, add immediate
    '{32'h0000_1000, 1'b0, 12'h010, 32'h0, 2'b00, 5'd0, 1'b0, 2'b00, 2'b10, 32'h0000_1010, 1'b0, 32'h0000_1010, 2'b10, 8'd1},
    // R2: pre-indexed, subtract immediate, byte
    '{32'h0000_1000, 1'b0, 12'h004, 32'h0, 2'b00, 5'd0, 1'b1, 2'b01, 2'b00, 32'h0000_0FFC, 1'b1, 32'h0000_0FFC, 2'b00, 8'd2},
    // R4 and R9: reserved mode, reserved size
    '{32'h0000_0100, 1'b0, 12'h001, 32'h0, 2'b00, 5'd0, 1'b0, 2'b11, 2'b11, 32'h0000_0101, 1'b0, 32'h0000_0101, 2'b10, 8'd4},
    // R6: LSL by 4
    '{32'h0000_0000, 1'b1, 12'h000, 32'h0000_0003, 2'b00, 5'd4, 1'b0, 2'b00, 2'b10, 32'h0000_0030, 1'b0, 32'h0000_0030, 2'b10, 8'd6},
    // R6: LSR by 31, pre-indexed
    '{32'h0000_1000, 1'b1, 12'h000, 32'h8000_0000, 2'b01, 5'd31, 1'b0, 2'b01, 2'b10, 32'h0000_1001, 1'b1, 32'h0000_1001, 2'b10, 8'd6},
    // R6: ASR of negative operand
    '{32'h0000_0000, 1'b1, 12'h000, 32'h8000_0000, 2'b10, 5'd4, 1'b0, 2'b00, 2'b10, 32'hF800_0000, 1'b0, 32'hF800_0000, 2'b10, 8'd6},
    // R6: ROR by 4
    '{32'h0000_0000, 1'b1, 12'h000, 32'h0000_00F1, 2'b11, 5'd4, 1'b0, 2'b00, 2'b10, 32'h1000_000F, 1'b0, 32'h1000_000F, 2'b10, 8'd6},
    // R7: ASR by 0 passes through
    '{32'h0000_0001, 1'b1, 12'h000, 32'h8000_0001, 2'b10, 5'd0, 1'b0, 2'b00, 2'b10, 32'h8000_0002, 1'b0, 32'h8000_0002, 2'b10, 8'd7},
    // R7: ROR by 0 passes through, halfword
    '{32'h0000_0000, 1'b1, 12'h000, 32'h1234_5678, 2'b11, 5'd0, 1'b0, 2'b00, 2'b01, 32'h1234_5678, 1'b0, 32'h1234_5678, 2'b01, 8'd7},
    // R8: add wraps past 2^32
    '{32'hFFFF_FFF0, 1'b0, 12'h020, 32'h0, 2'b00, 5'd0, 1'b0, 2'b01, 2'b10, 32'h0000_0010, 1'b1, 32'h0000_0010, 2'b10, 8'd8},
    // R8: subtract wraps below 0, post-indexed
    '{32'h0000_0004, 1'b1, 12'h000, 32'h0000_0008, 2'b00, 5'd0, 1'b1, 2'b10, 2'b10, 32'h0000_0004, 1'b1, 32'hFFFF_FFFC, 2'b10, 8'd8},
    // R5: immediate selected, register operand ignored
    '{32'h0000_0000, 1'b0, 12'hFFF, 32'h0000_DEAD, 2'b00, 5'd3, 1'b0, 2'b00, 2'b10, 32'h0000_0FFF, 1'b0, 32'h0000_0FFF, 2'b10, 8'd5}
  };

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    chk("R11", "valid in reset", {31'b0, valid_o}, 32'h0);
    chk("R11", "addr in reset", addr_o, 32'h0);
    chk("R11", "wb_val in reset", wb_val_o, 32'h0);
    chk("R11", "wb_en in reset", {31'b0, wb_en_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "valid before req", {31'b0, valid_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[i].rq);
      base_i = VEC[i].base; use_reg_i = VEC[i].use_reg; imm_i = VEC[i].imm;
      roff_i = VEC[i].roff; shtype_i = VEC[i].sht; shamt_i = VEC[i].sha;
      sub_i = VEC[i].sub; mode_i = VEC[i].mode; size_i = VEC[i].size;
      req_i = 1'b1;
      @(negedge clk);
      chk("R10", $sformatf("valid vec %0d", i), {31'b0, valid_o}, 32'h1);
      chk(tag, $sformatf("addr vec %0d", i), addr_o, VEC[i].e_addr);
      chk(tag, $sformatf("wb_en vec %0d", i), {31'b0, wb_en_o}, {31'b0, VEC[i].e_wb});
      chk(tag, $sformatf("wb_val vec %0d", i), wb_val_o, VEC[i].e_wbv);
      chk("R9", $sformatf("size vec %0d", i), {30'b0, size_o}, {30'b0, VEC[i].e_size});
    end

    // R10: idle cycle drops strobe and writeback, holds address
    held = addr_o;
    mode_i = 2'b01; base_i = 32'hAAAA_0000; req_i = 1'b0;
    @(negedge clk);
    chk("R10", "valid after idle", {31'b0, valid_o}, 32'h0);
    chk("R10", "wb_en after idle", {31'b0, wb_en_o}, 32'h0);
    chk("R10", "addr held", addr_o, held);

    // R2: pre-indexed writeback after idle, then single-cycle strobe
    base_i = 32'h0000_0040; use_reg_i = 1'b0; imm_i = 12'h008; sub_i = 1'b0;
    mode_i = 2'b01; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    chk("R2", "pre addr", addr_o, 32'h0000_0048);
    chk("R2", "pre wb_en", {31'b0, wb_en_o}, 32'h1);
    @(negedge clk);
    chk("R10", "strobe one cycle", {31'b0, valid_o}, 32'h0);

    // R11: reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11", "addr after reset", addr_o, 32'h0);
    chk("R11", "size after reset", {30'b0, size_o}, 32'h0);
    rst_n = 1'b1;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule